// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the hardware steps a small 32-bit core takes when it enters an exception or interrupt handler. A request arrives with a 2-bit cause and the vectors that could apply. The sequencer captures the core's program counter, delay-slot offset, status word and stack pointers, then moves through a fixed series of states. Along the way it writes the return-address register that matches the cause, the exception-status word, the swapped stack pointers and the rewritten status word. It then issues one word read to fetch the handler address into the PC and raises a one-cycle completion pulse.

The register file and memory sit outside the block. Each register the block updates has its own write-enable/data pair, and the handler fetch is a valid/ready read port. When the core version input is below a parameter threshold, a reduced older sequence runs in place of the current one.

Top module: `exc_entry_seq`

## Requirements
- R1: The vector depends on the cause (0 break, 1 NMI, 2 bus fault, 3 interrupt). Break takes `trap_vec`, NMI takes 0, bus fault takes `fault_vec` and interrupt takes `irq_vec`. The fetch address is `vbase + 4*vector`.
- R2: On the current path, NMI writes the captured PC to the NMI return register and clears status bit M_BIT (default 9) before the status rewrite. Every other cause writes the exception return register. Only one return register is written per entry.
- R3: On the current path, the exception-status word is written once: the vector in bits 15:8 and zeros elsewhere.
- R4: On the current path, the exception return value is the captured PC minus the 3-bit delay-slot offset. When that offset is non-zero, `dslot_clr` pulses once.
- R5: When status bit U_BIT (default 8) is set at entry, the old SP goes to the user SP register and SP is loaded from the kernel SP. When the bit is clear, neither is written.
- R6: On the current path, the status register is written once with bits 31:30 kept, old bits 19:0 placed in 29:10, and bits 9:0 zero.
- R7: The handler word read holds `mem_valid` and `mem_addr` steady until `mem_ready`. In the handshake cycle, `pc_we` writes `mem_rdata` to the PC.
- R8: When `ver_in` < LEGACY_VER (default 32), break and NMI save the PC to the breakpoint return register and interrupts save it to the exception return register. No exception-status write, rewind or shift takes place. After the fetch, a single status write sets bit F_BIT (default 10), with M_BIT also cleared for NMI.
- R9: A bus-fault request on the legacy path pulses `fatal` in its cycle and starts no entry. The block stays ready.
- R10: A bus-fault request made while a current-path bus-fault entry is pending, up to and including the fetch handshake cycle, raises `fatal` in that cycle. The pending mark clears at the handshake, and requests made during any other entry never raise `fatal`.
- R11: After reset and between entries, `req_ready` is 1 and nothing is written. Requests are accepted only while `req_ready` is 1.
- R12: `done` is a single-cycle pulse after the handler fetch, once per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Entry request |
| req_cause | input | 2 | Cause code |
| req_dslot | input | 3 | Delay-slot rewind amount, 0 when not in a slot |
| req_ready | output | 1 | Idle, request accepted |
| trap_vec | input | 8 | Break vector |
| fault_vec | input | 8 | Vector latched at bus fault |
| irq_vec | input | 8 | Interrupt controller vector |
| ver_in | input | 8 | Core version |
| pc_in | input | 32 | Current PC |
| status_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Kernel stack pointer |
| vbase_in | input | 32 | Vector table base |
| ret_exc_we | output | 1 | Exception return register write |
| ret_nmi_we | output | 1 | NMI return register write |
| ret_brk_we | output | 1 | Breakpoint return register write |
| ret_wd | output | 32 | Return-address write data |
| xstat_we | output | 1 | Exception-status write |
| xstat_wd | output | 32 | Exception-status data |
| dslot_clr | output | 1 | Clear delay-slot indicator |
| status_we | output | 1 | Status write |
| status_wd | output | 32 | Status data |
| usp_we | output | 1 | User SP write |
| usp_wd | output | 32 | User SP data |
| sp_we | output | 1 | SP write |
| sp_wd | output | 32 | SP data |
| mem_valid | output | 1 | Handler fetch request |
| mem_addr | output | 32 | Handler fetch address |
| mem_ready | input | 1 | Fetch accepted, data valid |
| mem_rdata | input | 32 | Handler address read |
| pc_we | output | 1 | PC write |
| pc_wd | output | 32 | PC data |
| done | output | 1 | Entry complete |
| fatal | output | 1 | Recursive or unsupported bus fault |

## Verification
Two events can land in the same cycle: a new bus-fault request arriving and the fetch handshake that clears the pending mark. The bench holds a bus-fault request high for the whole of a bus-fault entry, with the fetch stalled for several cycles. It expects `fatal` in every busy cycle up to and including the `pc_we` cycle and not in the `done` cycle. The same request held through an interrupt entry must never raise `fatal`.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN = 32;
  localparam int VW   = 8;

  typedef enum logic [1:0] {
    CAUSE_BRK = 2'd0,
    CAUSE_NMI = 2'd1,
    CAUSE_BUS = 2'd2,
    CAUSE_IRQ = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SAVE, ST_STACK, ST_STATUS, ST_FETCH, ST_DONE
  } state_e;

  // Mode-history shift of the status word.
  function automatic logic [XLEN-1:0] mode_shift(input logic [XLEN-1:0] s);
    return {s[31:30], s[19:0], 10'b0};
  endfunction

  function automatic logic [XLEN-1:0] xstat_word(input logic [VW-1:0] v);
    return {{(XLEN-VW-8){1'b0}}, v, 8'b0};
  endfunction

  function automatic logic [XLEN-1:0] handler_addr(input logic [XLEN-1:0] base,
                                                   input logic [VW-1:0] v);
    return base + {{(XLEN-VW-2){1'b0}}, v, 2'b00};
  endfunction
endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
  import exc_entry_pkg::*;
(
  input  logic [1:0]    cause,
  input  logic [VW-1:0] trap_vec,
  input  logic [VW-1:0] fault_vec,
  input  logic [VW-1:0] irq_vec,
  output logic [VW-1:0] vec
);
  always_comb begin
    unique case (cause_e'(cause))
      CAUSE_BRK: vec = trap_vec;
      CAUSE_NMI: vec = '0;
      CAUSE_BUS: vec = fault_vec;
      default:   vec = irq_vec;
    endcase
  end
endmodule

// File: rtl/exc_frame_calc.sv
module exc_frame_calc
  import exc_entry_pkg::*;
#(
  parameter int M_BIT = 9,
  parameter int F_BIT = 10
) (
  input  logic            legacy,
  input  logic            is_nmi,
  input  logic [XLEN-1:0] pc,
  input  logic [2:0]      dslot,
  input  logic [XLEN-1:0] status,
  input  logic [VW-1:0]   vec,
  output logic [XLEN-1:0] ret_exc,
  output logic [XLEN-1:0] status_next,
  output logic [XLEN-1:0] xstat
);
  logic [XLEN-1:0] masked;

  always_comb begin
    masked = status;
    if (is_nmi) masked[M_BIT] = 1'b0;
    ret_exc     = legacy ? pc : pc - {{(XLEN-3){1'b0}}, dslot};
    status_next = legacy ? (masked | (XLEN'(1) << F_BIT)) : mode_shift(masked);
    xstat       = xstat_word(vec);
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int LEGACY_VER = 32,
  parameter int U_BIT      = 8,
  parameter int M_BIT      = 9,
  parameter int F_BIT      = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_cause,
  input  logic [2:0]  req_dslot,
  output logic        req_ready,
  input  logic [7:0]  trap_vec,
  input  logic [7:0]  fault_vec,
  input  logic [7:0]  irq_vec,
  input  logic [7:0]  ver_in,
  input  logic [31:0] pc_in,
  input  logic [31:0] status_in,
  input  logic [31:0] sp_in,
  input  logic [31:0] ksp_in,
  input  logic [31:0] vbase_in,
  output logic        ret_exc_we,
  output logic        ret_nmi_we,
  output logic        ret_brk_we,
  output logic [31:0] ret_wd,
  output logic        xstat_we,
  output logic [31:0] xstat_wd,
  output logic        dslot_clr,
  output logic        status_we,
  output logic [31:0] status_wd,
  output logic        usp_we,
  output logic [31:0] usp_wd,
  output logic        sp_we,
  output logic [31:0] sp_wd,
  output logic        mem_valid,
  output logic [31:0] mem_addr,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  output logic        pc_we,
  output logic [31:0] pc_wd,
  output logic        done,
  output logic        fatal
);
  state_e          state;
  logic [1:0]      s_cause;
  logic [2:0]      s_dslot;
  logic [VW-1:0]   s_vec;
  logic            s_legacy;
  logic [XLEN-1:0] s_pc, s_status, s_sp, s_ksp, s_vbase;
  logic            pend_bus;

  logic [VW-1:0]   vec_now;
  logic            legacy_now, accept, leg_bus, s_nmi, s_user;
  logic [XLEN-1:0] ret_exc_val, status_next, xstat_val;

  exc_vec_sel u_vec (
    .cause(req_cause), .trap_vec(trap_vec), .fault_vec(fault_vec),
    .irq_vec(irq_vec), .vec(vec_now)
  );

  exc_frame_calc #(.M_BIT(M_BIT), .F_BIT(F_BIT)) u_frame (
    .legacy(s_legacy), .is_nmi(s_nmi), .pc(s_pc), .dslot(s_dslot),
    .status(s_status), .vec(s_vec), .ret_exc(ret_exc_val),
    .status_next(status_next), .xstat(xstat_val)
  );

  assign legacy_now = ({24'b0, ver_in} < LEGACY_VER);
  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign leg_bus    = accept && legacy_now && (req_cause == CAUSE_BUS);
  assign s_nmi      = (s_cause == CAUSE_NMI);
  assign s_user     = s_status[U_BIT];
  assign fatal      = leg_bus || (req_valid && req_cause == CAUSE_BUS && pend_bus);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      s_cause  <= '0;
      s_dslot  <= '0;
      s_vec    <= '0;
      s_legacy <= 1'b0;
      s_pc     <= '0;
      s_status <= '0;
      s_sp     <= '0;
      s_ksp    <= '0;
      s_vbase  <= '0;
      pend_bus <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept && !leg_bus) begin
          state    <= ST_SAVE;
          s_cause  <= req_cause;
          s_dslot  <= req_dslot;
          s_vec    <= vec_now;
          s_legacy <= legacy_now;
          s_pc     <= pc_in;
          s_status <= status_in;
          s_sp     <= sp_in;
          s_ksp    <= ksp_in;
          s_vbase  <= vbase_in;
          pend_bus <= (req_cause == CAUSE_BUS);
        end
        ST_SAVE:   state <= ST_STACK;
        ST_STACK:  state <= ST_STATUS;
        ST_STATUS: state <= ST_FETCH;
        ST_FETCH: if (mem_ready) begin
          state    <= ST_DONE;
          pend_bus <= 1'b0;
        end
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ret_exc_we = 1'b0;
    ret_nmi_we = 1'b0;
    ret_brk_we = 1'b0;
    ret_wd     = s_pc;
    xstat_we   = 1'b0;
    dslot_clr  = 1'b0;
    status_we  = 1'b0;
    usp_we     = 1'b0;
    sp_we      = 1'b0;
    mem_valid  = 1'b0;
    pc_we      = 1'b0;
    done       = 1'b0;
    unique case (state)
      ST_SAVE: begin
        if (s_legacy) begin
          ret_brk_we = (s_cause == CAUSE_BRK) || s_nmi;
          ret_exc_we = (s_cause == CAUSE_IRQ);
        end else begin
          ret_nmi_we = s_nmi;
          ret_exc_we = !s_nmi;
          ret_wd     = s_nmi ? s_pc : ret_exc_val;
          xstat_we   = 1'b1;
          dslot_clr  = (s_dslot != 3'd0);
        end
      end
      ST_STACK: begin
        usp_we = s_user;
        sp_we  = s_user;
      end
      ST_STATUS: status_we = !s_legacy;
      ST_FETCH: begin
        mem_valid = 1'b1;
        pc_we     = mem_ready;
      end
      ST_DONE: begin
        done      = 1'b1;
        status_we = s_legacy;
      end
      default: ;
    endcase
  end

  assign xstat_wd  = xstat_val;
  assign status_wd = status_next;
  assign usp_wd    = s_sp;
  assign sp_wd     = s_ksp;
  assign mem_addr  = handler_addr(s_vbase, s_vec);
  assign pc_wd     = mem_rdata;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        ret_exc_we,
  input logic        ret_nmi_we,
  input logic        ret_brk_we,
  input logic        xstat_we,
  input logic [31:0] xstat_wd,
  input logic        usp_we,
  input logic        sp_we,
  input logic        mem_valid,
  input logic [31:0] mem_addr,
  input logic        mem_ready,
  input logic        pc_we,
  input logic        done
);
  assert_one_ret_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ret_exc_we, ret_nmi_we, ret_brk_we}));

  assert_xstat_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xstat_we |-> (xstat_wd[31:16] == 16'h0 && xstat_wd[7:0] == 8'h0));

  assert_swap_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    usp_we == sp_we);

  assert_fetch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  assert_pc_on_handshake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (mem_valid && mem_ready));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(mem_valid || done || status_we_free(xstat_we, usp_we)));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> done);

  function automatic logic status_we_free(input logic a, input logic b);
    return a | b;
  endfunction
endmodule

bind exc_entry_seq exc_entry_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .ret_exc_we(ret_exc_we), .ret_nmi_we(ret_nmi_we), .ret_brk_we(ret_brk_we),
  .xstat_we(xstat_we), .xstat_wd(xstat_wd), .usp_we(usp_we), .sp_we(sp_we),
  .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_ready(mem_ready),
  .pc_we(pc_we), .done(done)
);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_ready;
  logic [1:0]  req_cause = 0;
  logic [2:0]  req_dslot = 0;
  logic [7:0]  trap_vec = 8'h21, fault_vec = 8'h37, irq_vec = 8'h5C, ver_in = 8'd40;
  logic [31:0] pc_in = 0, status_in = 0, sp_in = 0, ksp_in = 0, vbase_in = 0;
  logic        ret_exc_we, ret_nmi_we, ret_brk_we, xstat_we, dslot_clr, status_we;
  logic        usp_we, sp_we, mem_valid, pc_we, done, fatal;
  logic [31:0] ret_wd, xstat_wd, status_wd, usp_wd, sp_wd, mem_addr, pc_wd;
  logic        mem_ready = 0;
  logic [31:0] mem_rdata = 0;

  exc_entry_seq u0 (.*);

  int tests = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference arithmetic, restated independently.
  function automatic logic [31:0] ref_shift(input logic [31:0] s);
    return (s & 32'hC000_0000) | (((s << 12) >> 2) & ~32'h0000_03FF);
  endfunction

  function automatic int ref_vec(input int c);
    if (c == 0) return trap_vec;
    if (c == 1) return 0;
    if (c == 2) return fault_vec;
    return irq_vec;
  endfunction

  task automatic run_entry(input int cause, input int dsl, input bit user,
                           input bit legacy, input int delay, input bit hammer);
    int n_exc = 0, n_nmi = 0, n_brk = 0, n_xs = 0, n_clr = 0, n_st = 0;
    int n_usp = 0, n_sp = 0, n_pc = 0, n_done = 0, waited = 0, fatal_bad = 0;
    logic [31:0] v_exc = 0, v_nmi = 0, v_brk = 0, v_xs = 0, v_st = 0, v_usp = 0, v_sp = 0, v_pc = 0;
    logic [31:0] first_addr = 0;
    bit addr_moved = 0, seen_pc = 0;
    int vec = ref_vec(cause);
    logic [31:0] pc = 32'h4000_1230 + 32'(cause * 16);
    logic [31:0] st = (32'hA5C3_3C7F | 32'h200) & ~32'h100;
    logic [31:0] exp_st, handler;
    if (user) st = st | 32'h100;
    handler = 32'hC0DE_0000 ^ 32'(vec);
    @(negedge clk);
    req_cause = 2'(cause); req_dslot = 3'(dsl); ver_in = legacy ? 8'd10 : 8'd40;
    pc_in = pc; status_in = st; sp_in = 32'h0007_FF00; ksp_in = 32'h0001_0000;
    vbase_in = 32'h0000_8000; mem_rdata = handler; req_valid = 1;
    #1;
    chk("R11 ready at request", {31'b0, req_ready}, 1);
    if (legacy && cause == 2) chk("R9 fatal on legacy bus fault", {31'b0, fatal}, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = hammer;
    if (hammer) req_cause = 2'd2;
    if (legacy && cause == 2) begin
      #1;
      chk("R9 still ready", {31'b0, req_ready}, 1);
      chk("R9 no fetch or writes", {28'b0, mem_valid, ret_exc_we, ret_brk_we, usp_we}, 0);
      return;
    end
    for (int cyc = 0; cyc < 40; cyc++) begin
      if (mem_valid) begin
        mem_ready = (waited == delay);
        waited++;
      end else mem_ready = 0;
      #1;
      if (hammer && fatal !== ((cause == 2) && !seen_pc && !done)) fatal_bad++;
      if (ret_exc_we) begin n_exc++; v_exc = ret_wd; end
      if (ret_nmi_we) begin n_nmi++; v_nmi = ret_wd; end
      if (ret_brk_we) begin n_brk++; v_brk = ret_wd; end
      if (xstat_we)   begin n_xs++;  v_xs  = xstat_wd; end
      if (dslot_clr)  n_clr++;
      if (status_we)  begin n_st++;  v_st  = status_wd; end
      if (usp_we)     begin n_usp++; v_usp = usp_wd; end
      if (sp_we)      begin n_sp++;  v_sp  = sp_wd; end
      if (mem_valid) begin
        if (waited == 1) first_addr = mem_addr;
        else if (mem_addr !== first_addr) addr_moved = 1;
      end
      if (pc_we) begin n_pc++; v_pc = pc_wd; seen_pc = 1; end
      if (done) begin
        n_done++;
        req_valid = 0; mem_ready = 0;
        break;
      end
      @(negedge clk);
    end
    chk("R1 fetch address", first_addr, 32'h0000_8000 + 32'(vec * 4));
    chk("R7 address held during wait", {31'b0, addr_moved}, 0);
    chk("R7 wait length", 32'(waited), 32'(delay + 1));
    chk("R7 pc write count", 32'(n_pc), 1);
    chk("R7 pc value", v_pc, handler);
    chk("R12 done count", 32'(n_done), 1);
    chk("R5 usp writes", 32'(n_usp), user ? 1 : 0);
    chk("R5 sp writes", 32'(n_sp), user ? 1 : 0);
    if (user) begin
      chk("R5 usp value", v_usp, 32'h0007_FF00);
      chk("R5 sp value", v_sp, 32'h0001_0000);
    end
    if (hammer) chk("R10 fatal window", 32'(fatal_bad), 0);
    if (!legacy) begin
      exp_st = ref_shift(cause == 1 ? st & ~32'h200 : st);
      chk("R2 nmi return count", 32'(n_nmi), cause == 1 ? 1 : 0);
      chk("R2 exc return count", 32'(n_exc), cause == 1 ? 0 : 1);
      chk("R2 brk return count", 32'(n_brk), 0);
      if (cause == 1) chk("R2 nmi return value", v_nmi, pc);
      else chk("R4 rewound return value", v_exc, pc - 32'(dsl));
      chk("R4 dslot clear count", 32'(n_clr), dsl != 0 ? 1 : 0);
      chk("R3 xstat count", 32'(n_xs), 1);
      chk("R3 xstat value", v_xs, 32'(vec) << 8);
      chk("R6 status count", 32'(n_st), 1);
      chk("R6 status value", v_st, exp_st);
    end else begin
      exp_st = (cause == 1 ? st & ~32'h200 : st) | 32'h400;
      chk("R8 brk return count", 32'(n_brk), (cause == 0 || cause == 1) ? 1 : 0);
      chk("R8 exc return count", 32'(n_exc), cause == 3 ? 1 : 0);
      chk("R8 nmi return count", 32'(n_nmi), 0);
      if (cause != 3) chk("R8 brk value unrewound", v_brk, pc);
      else chk("R8 exc value unrewound", v_exc, pc);
      chk("R8 no xstat", 32'(n_xs), 0);
      chk("R8 no dslot clear", 32'(n_clr), 0);
      chk("R8 status count", 32'(n_st), 1);
      chk("R8 status value with F", v_st, exp_st);
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R11 reset ready", {31'b0, req_ready}, 1);
    chk("R11 reset quiet", {26'b0, mem_valid, done, status_we, xstat_we, ret_exc_we, fatal}, 0);
    rst_n = 1;
    run_entry(0, 0, 0, 0, 0, 0);  // break, kernel
    run_entry(1, 2, 1, 0, 3, 0);  // NMI, user, in slot
    run_entry(2, 4, 0, 0, 1, 0);  // bus fault, in slot
    run_entry(3, 0, 1, 0, 2, 0);  // interrupt, user
    run_entry(3, 7, 0, 0, 0, 0);  // interrupt, max rewind
    run_entry(0, 3, 1, 1, 1, 0);  // legacy break, slot ignored
    run_entry(1, 0, 0, 1, 0, 0);  // legacy NMI
    run_entry(3, 5, 0, 1, 2, 0);  // legacy interrupt
    run_entry(2, 0, 0, 1, 0, 0);  // legacy bus fault: fatal
    run_entry(2, 1, 0, 0, 4, 1);  // R10 recursive bus fault held through entry
    run_entry(3, 0, 1, 0, 2, 1);  // R10 bus request during interrupt: no fatal
    run_entry(2, 0, 1, 0, 0, 0);  // R10 later bus fault taken normally
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule